// File: doc/BRIEF.md
# Two-Hop Distinct Channel Selector

This block chooses the spreading-code channel a sensor node transmits on. Channels come from a small shared pool, and every node in a large mesh reuses them. Each node must hold a channel that no node within two hops is using. Neighbours send assignment records over a shared control channel. Each record gives the sender's ID, the sender's channel and a bitmap of the channels the sender's own direct neighbours use. The block accepts these records on a valid/data strobe and keeps them in a small neighbour table. From the table it forms an occupancy bitmap that covers the whole two-hop neighbourhood.

When a direct neighbour claims the node's channel, the ID decides who gives way: the node with the larger ID moves. The moving node takes the lowest-numbered channel that is free in the occupancy bitmap. If every channel is taken, the node keeps its channel and raises a conflict flag. A timer driven by a tick enable asks the framing logic to broadcast the node's own record once per programmable period. The same period event ages the table, so neighbours that go silent drop out of the occupancy bitmap.

Top module: `ch2hop_sel`

## Requirements
- R1: After reset the selected channel is 0, the conflict flag and broadcast request are low, and the occupancy bitmap is all zeros.
- R2: A record is stored when it is accepted. From the following cycle, the occupancy bitmap has the bit for the sender's channel set, and every bit of the sender's reported one-hop bitmap set, where bit n stands for channel n.
- R3: A record whose ID is already in the table replaces that entry's channel and bitmap. Bits that only the old contents contributed leave the occupancy bitmap, and no second entry is made.
- R4: One age event occurs at each completed broadcast period. After four such events with no refresh, an entry is removed from the occupancy bitmap. A refresh restarts the count.
- R5: A neighbour may hold the same channel as the node while having a smaller ID. In that case the selected channel changes to the lowest-numbered channel that is clear in the occupancy bitmap. The change takes effect one cycle after the table update.
- R6: A neighbour may hold the same channel as the node while having a larger ID. In that case the node keeps its channel and the conflict flag stays low.
- R7: The node may be required to move while the occupancy bitmap is all ones. It then keeps its channel and the conflict flag is high. The flag clears once a move succeeds.
- R8: The broadcast request is a one-cycle pulse in the cycle after every period-th tick. A period value of 0 behaves as 1.
- R9: A record from a new ID is dropped when all 8 table entries are in use.
- R10: A record carrying the node's own ID is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_id_i | input | 8 | This node's ID |
| rec_valid_i | input | 1 | Received record strobe |
| rec_id_i | input | 8 | Sender ID |
| rec_ch_i | input | 5 | Sender's channel |
| rec_map_i | input | 32 | Channels used by the sender's one-hop neighbours |
| tick_i | input | 1 | Timer tick enable |
| period_i | input | 16 | Ticks per broadcast period |
| own_ch_o | output | 5 | Selected channel |
| conflict_o | output | 1 | Move required but no free channel |
| bcast_req_o | output | 1 | Broadcast own record request pulse |
| occ_o | output | 32 | Two-hop occupancy bitmap |

## Verification
The occupancy bitmap is a direct view of the table contents. A lost refresh, a duplicated entry or an off-by-one age counter therefore shows up on occ_o in the cycle after the record or age event that triggered it. A wrong tie-break or a wrong priority scan shows up one cycle later as an unexpected own_ch_o value or a stuck conflict_o. Broadcast timing errors show up as pulses that are missing or shifted by one tick relative to the programmed period.

// File: rtl/ch2hop_pkg.sv
package ch2hop_pkg;
  localparam int unsigned NUM_CH = 32;
  localparam int unsigned ID_W   = 8;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned AGE_W  = 3;

  typedef struct packed {
    logic              vld;
    logic [ID_W-1:0]   id;
    logic [CH_W-1:0]   ch;
    logic [NUM_CH-1:0] nmap;
    logic [AGE_W-1:0]  age;
  } nbr_ent_t;
endpackage

// File: rtl/bcast_timer.sv
module bcast_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             hit_o,
  output logic             pulse_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + 1'b1;
  assign hit_o = tick_i && (nxt >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= hit_o;
      if (hit_o)       cnt_q <= '0;
      else if (tick_i) cnt_q <= nxt[PER_W-1:0];
    end
  end

  a_r8_pulse_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(tick_i));
endmodule

// File: rtl/nbr_table.sv
module nbr_table
  import ch2hop_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned AGE_MAX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   my_id_i,
  input  logic              rec_valid_i,
  input  logic [ID_W-1:0]   rec_id_i,
  input  logic [CH_W-1:0]   rec_ch_i,
  input  logic [NUM_CH-1:0] rec_map_i,
  input  logic              age_evt_i,
  output nbr_ent_t          tbl_o [DEPTH]
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  nbr_ent_t           tbl_q [DEPTH];
  logic               hit_found, free_found, accept;
  logic [IDX_W-1:0]   hit_idx, free_idx, wr_idx;
  logic [DEPTH-1:0]   vld_vec;

  always_comb begin
    hit_found  = 1'b0;
    free_found = 1'b0;
    hit_idx    = '0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      vld_vec[i] = tbl_q[i].vld;
      if (tbl_q[i].vld && tbl_q[i].id == rec_id_i) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
      if (!tbl_q[i].vld) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    wr_idx = hit_found ? hit_idx : free_idx;
    accept = rec_valid_i && (rec_id_i != my_id_i) && (hit_found || free_found);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (accept && wr_idx == IDX_W'(i)) begin
          tbl_q[i].vld  <= 1'b1;
          tbl_q[i].id   <= rec_id_i;
          tbl_q[i].ch   <= rec_ch_i;
          tbl_q[i].nmap <= rec_map_i;
          tbl_q[i].age  <= '0;
        end else if (age_evt_i && tbl_q[i].vld) begin
          if (tbl_q[i].age == AGE_W'(AGE_MAX - 1)) begin
            tbl_q[i].vld <= 1'b0;
            tbl_q[i].age <= '0;
          end else begin
            tbl_q[i].age <= tbl_q[i].age + 1'b1;
          end
        end
      end
    end
  end

  assign tbl_o = tbl_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    a_r4_age_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_q[g].vld |-> tbl_q[g].age < AGE_W'(AGE_MAX));
  end

  a_r10_self_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_id_i == my_id_i && !age_evt_i) |=> $stable(vld_vec));
endmodule

// File: rtl/chan_pick.sv
module chan_pick
  import ch2hop_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   my_id_i,
  input  nbr_ent_t          tbl_i [DEPTH],
  output logic [CH_W-1:0]   own_ch_o,
  output logic              conflict_o,
  output logic [NUM_CH-1:0] occ_o
);
  logic [NUM_CH-1:0] occ;
  logic              need_move, any_free;
  logic [CH_W-1:0]   pick;

  always_comb begin
    occ       = '0;
    need_move = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (tbl_i[i].vld) begin
        occ = occ | tbl_i[i].nmap | ({{(NUM_CH-1){1'b0}}, 1'b1} << tbl_i[i].ch);
        // larger ID yields
        if (tbl_i[i].ch == own_ch_o && tbl_i[i].id < my_id_i) need_move = 1'b1;
      end
    end
    any_free = 1'b0;
    pick     = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (!occ[c]) begin
        any_free = 1'b1;
        pick     = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_ch_o   <= '0;
      conflict_o <= 1'b0;
    end else if (need_move) begin
      if (any_free) begin
        own_ch_o   <= pick;
        conflict_o <= 1'b0;
      end else begin
        conflict_o <= 1'b1;
      end
    end else begin
      conflict_o <= 1'b0;
    end
  end

  assign occ_o = occ;

  a_r5_move_to_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_ch_o != $past(own_ch_o)) |-> ((($past(occ) >> own_ch_o) & 32'd1) == 32'd0));

  a_r7_hold_on_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> own_ch_o == $past(own_ch_o));
endmodule

// File: rtl/ch2hop_sel.sv
module ch2hop_sel
  import ch2hop_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned AGE_MAX = 4,
  parameter int unsigned PER_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   my_id_i,
  input  logic              rec_valid_i,
  input  logic [ID_W-1:0]   rec_id_i,
  input  logic [CH_W-1:0]   rec_ch_i,
  input  logic [NUM_CH-1:0] rec_map_i,
  input  logic              tick_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [CH_W-1:0]   own_ch_o,
  output logic              conflict_o,
  output logic              bcast_req_o,
  output logic [NUM_CH-1:0] occ_o
);
  nbr_ent_t tbl [DEPTH];
  logic     age_evt;

  bcast_timer #(.PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .tick_i, .period_i,
    .hit_o(age_evt), .pulse_o(bcast_req_o)
  );

  nbr_table #(.DEPTH(DEPTH), .AGE_MAX(AGE_MAX)) u_table (
    .clk_i, .rst_ni, .my_id_i, .rec_valid_i, .rec_id_i, .rec_ch_i, .rec_map_i,
    .age_evt_i(age_evt), .tbl_o(tbl)
  );

  chan_pick #(.DEPTH(DEPTH)) u_pick (
    .clk_i, .rst_ni, .my_id_i, .tbl_i(tbl),
    .own_ch_o, .conflict_o, .occ_o
  );
endmodule

// File: tb/tb_ch2hop_sel.sv
`timescale 1ns/1ps
module tb_ch2hop_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  my_id = 8'h40;
  logic        rec_valid = 1'b0;
  logic [7:0]  rec_id = '0;
  logic [4:0]  rec_ch = '0;
  logic [31:0] rec_map = '0;
  logic        tick = 1'b0;
  logic [15:0] period = 16'd1;
  logic [4:0]  own_ch;
  logic        conflict;
  logic        bcast;
  logic [31:0] occ;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ch2hop_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .my_id_i(my_id),
    .rec_valid_i(rec_valid), .rec_id_i(rec_id), .rec_ch_i(rec_ch), .rec_map_i(rec_map),
    .tick_i(tick), .period_i(period),
    .own_ch_o(own_ch), .conflict_o(conflict), .bcast_req_o(bcast), .occ_o(occ)
  );

  // {id, ch, map, exp_own, exp_conflict, exp_occ}, applied in order, node ID 0x40
  localparam logic [82:0] VEC [0:7] = '{
    {8'h10, 5'd5, 32'h0000_0280, 5'd0, 1'b0, 32'h0000_02A0}, // R2 two-hop bits
    {8'h10, 5'd6, 32'h0000_0001, 5'd0, 1'b0, 32'h0000_0041}, // R3 refresh
    {8'h20, 5'd0, 32'h0000_0000, 5'd1, 1'b0, 32'h0000_0041}, // R5 smaller ID, move
    {8'h50, 5'd1, 32'h0000_0004, 5'd1, 1'b0, 32'h0000_0047}, // R6 larger ID, stay
    {8'h30, 5'd1, 32'h0000_0008, 5'd4, 1'b0, 32'h0000_004F}, // R5 lowest free
    {8'h40, 5'd4, 32'hFFFF_FFFF, 5'd4, 1'b0, 32'h0000_004F}, // R10 own ID
    {8'h11, 5'd4, 32'hFFFF_FFFF, 5'd4, 1'b1, 32'hFFFF_FFFF}, // R7 all busy
    {8'h11, 5'd4, 32'h0000_0000, 5'd5, 1'b0, 32'h0000_005F}  // R7 clears
  };

  function automatic string vec_req(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      4: return "R5";
      5: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] id, input logic [4:0] ch, input logic [31:0] m);
    @(negedge clk);
    rec_valid = 1'b1; rec_id = id; rec_ch = ch; rec_map = m;
    @(negedge clk);
    rec_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_tick(output logic pulse);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    pulse = bcast;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 own", 32'(own_ch), 32'd0);
    check("R1 conflict", 32'(conflict), 32'd0);
    check("R1 bcast", 32'(bcast), 32'd0);
    check("R1 occ", occ, 32'd0);

    for (int i = 0; i < 8; i++) begin
      send(VEC[i][82:75], VEC[i][74:70], VEC[i][69:38]);
      check({vec_req(i), " own"}, 32'(own_ch), 32'(VEC[i][37:33]));
      check({vec_req(i), " conflict"}, 32'(conflict), 32'(VEC[i][32]));
      check({vec_req(i), " occ"}, occ, VEC[i][31:0]);
    end

    // R9: fill to 8 entries, ninth ID dropped
    send(8'h60, 5'd20, 32'h0);
    send(8'h61, 5'd21, 32'h0);
    send(8'h62, 5'd22, 32'h0);
    send(8'h63, 5'd23, 32'h0);
    check("R9 occ", occ, 32'h0070_005F);

    // R4: aging with period 1
    period = 16'd1;
    repeat (3) do_tick(p);
    check("R4 after 3 ages", occ, 32'h0070_005F);
    send(8'h60, 5'd20, 32'h0);
    do_tick(p);
    check("R4 stale removed", occ, 32'h0010_0000);
    check("R4 own kept", 32'(own_ch), 32'd5);
    repeat (2) do_tick(p);
    check("R4 refreshed alive", occ, 32'h0010_0000);
    do_tick(p);
    check("R4 refreshed expires", occ, 32'h0);

    // R8: period 3
    period = 16'd3;
    do_tick(p); check("R8 tick1", 32'(p), 32'd0);
    do_tick(p); check("R8 tick2", 32'(p), 32'd0);
    do_tick(p); check("R8 tick3", 32'(p), 32'd1);
    @(negedge clk);
    check("R8 single pulse", 32'(bcast), 32'd0);
    period = 16'd0;
    do_tick(p); check("R8 period0", 32'(p), 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule